// File: doc/BRIEF.md
# Prescaled Serial Baud Tick Generator

This block produces the 16x oversampling enable for one asynchronous serial channel. The reference clock is first reduced by a prescaler that either passes every cycle through or keeps one cycle in four. A programmable 16-bit divisor then counts those prescaled steps, and the block emits a single-cycle enable each time the count expires. The enable therefore repeats every `ratio * divisor` reference cycles. For example, a 24 MHz reference with ratio 1 and divisor 1 gives a 1.5 Mbit/s line, and a 14.7456 MHz reference with ratio 1 gives 921.6 kbit/s at divisor 1 and 460.8 kbit/s at divisor 2.

A board strap sets the default prescaler ratio. The block samples the strap while reset is held and loads it into bit 7 of a control register. After reset, software may rewrite that bit to pick either ratio. The divisor is written as two byte registers through a small write port. Every divisor write restarts both counters, so the first enable after the write arrives one full new period later. A ratio change restarts the prescaler phase, so no partial prescaler period is produced.

Top module: `baud_prescale_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tick16_o` is 0. The divisor resets to 0, so no enable appears until software programs a divisor.
- R2: While `rst` is high, `strap_div4_i` is sampled into the ratio select, where 1 selects divide-by-4 and 0 selects divide-by-1. After reset, changes on the strap have no effect.
- R3: A write to address 2 sets the ratio select from data bit 7 (1 = divide-by-4). The other data bits of that write are ignored. A write to address 3 changes nothing.
- R4: A write to address 0 sets divisor bits 7:0, and a write to address 1 sets divisor bits 15:8. With divisor D greater than 0 and ratio N, `tick16_o` pulses once every N*D reference cycles. When N*D is greater than 1, each pulse is high for exactly one cycle.
- R5: With a divisor of 0, `tick16_o` stays at 0.
- R6: With divisor 1 and ratio 1, `tick16_o` stays high in every cycle.
- R7: A divisor write restarts both counters. `tick16_o` is 0 in the cycle after the write edge, and the first pulse appears N*D cycles after that edge.
- R8: A write that changes the ratio restarts the prescaler phase. `tick16_o` is 0 in the cycle after that write. With divisor 1, the next pulse comes exactly N_new cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_div4_i | input | 1 | Board strap for the default ratio, 1 = divide-by-4 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 control |
| wr_data_i | input | 8 | Write data |
| tick16_o | output | 1 | Registered single-cycle 16x sampling enable |

## Verification
The enable is registered, so a write sampled at edge E0 is visible in the sample taken after E0. At that point the bench checks that the enable is low. The bench then counts one unit per later edge, sampling on the falling edge, and the first pulse must land on count N*D. The next pulse must land exactly N*D counts after it. The ratio-change and strap cases use the same counting scheme from their own write or reset-release edge. Because each result is compared at its predicted count, an early or late pulse is reported even when its period is correct.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BG_DIV_W   = 16;
  localparam int BG_ADDR_W  = 2;
  localparam int BG_DATA_W  = 8;
  localparam int BG_PRE_MAX = 4;
  localparam int BG_SEL_BIT = 7;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DIV_W   = 16,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int SEL_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_next,
  output logic              div_load,
  output logic              sel_q,
  output logic              sel_change
);
  localparam int NBYTES    = DIV_W / DATA_W;
  localparam int CTRL_ADDR = NBYTES;

  logic [NBYTES-1:0] byte_hit;
  logic              ctrl_hit;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_hit[b] = wr_en && (wr_addr == ADDR_W'(b));
    assign div_next[b*DATA_W +: DATA_W] =
      byte_hit[b] ? wr_data : div_q[b*DATA_W +: DATA_W];
  end

  assign div_load   = |byte_hit;
  assign ctrl_hit   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign sel_change = ctrl_hit && (wr_data[SEL_BIT] != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sel_q <= strap;
    end else begin
      div_q <= div_next;
      if (ctrl_hit) sel_q <= wr_data[SEL_BIT];
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_div4,
  input  logic clear,
  output logic step
);
  localparam int PC_W = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

  logic [PC_W-1:0] phase_q;

  assign step = !clear && (!sel_div4 || (phase_q == PC_W'(PRE_MAX - 1)));

  always_ff @(posedge clk) begin
    if (rst || clear || !sel_div4) begin
      phase_q <= '0;
    end else if (phase_q == PC_W'(PRE_MAX - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      tick  <= 1'b0;
    end else if (step && (cnt_q == DIV_W'(1))) begin
      cnt_q <= div_val;
      tick  <= 1'b1;
    end else begin
      if (step && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_prescale_gen.sv
module baud_prescale_gen
  import baud_pkg::*;
#(
  parameter int DIV_W   = BG_DIV_W,
  parameter int ADDR_W  = BG_ADDR_W,
  parameter int DATA_W  = BG_DATA_W,
  parameter int PRE_MAX = BG_PRE_MAX,
  parameter int SEL_BIT = BG_SEL_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_div4_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tick16_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_next;
  logic             div_load;
  logic             sel_q;
  logic             sel_change;
  logic             step;

  baud_regs #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .strap(strap_div4_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .div_q(div_q), .div_next(div_next), .div_load(div_load),
    .sel_q(sel_q), .sel_change(sel_change)
  );

  baud_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
    .clk(clk), .rst(rst), .sel_div4(sel_q),
    .clear(div_load || sel_change), .step(step)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .step(step), .load(div_load),
    .load_val(div_next), .div_val(div_q), .tick(tick16_o)
  );
endmodule

// File: rtl/baud_prescale_chk.sv
module baud_prescale_chk #(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2,
  parameter int NBYTES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strap_div4_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              tick16_o,
  input logic [DIV_W-1:0]  div_q,
  input logic              sel_q
);
  logic div_wr;
  logic ctrl_wr;
  assign div_wr  = wr_en_i && (wr_addr_i < ADDR_W'(NBYTES));
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(NBYTES));

  p_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |-> !tick16_o);

  p_load_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    div_wr |=> !tick16_o);

  p_strap_take_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == $past(strap_div4_i)));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(sel_q));

  p_one_wide_r4: assert property (@(posedge clk) disable iff (rst)
    (tick16_o && (sel_q || div_q != DIV_W'(1))) |=> !tick16_o);

  p_div1_run_r6: assert property (@(posedge clk) disable iff (rst)
    (tick16_o && div_q == DIV_W'(1) && !sel_q && !wr_en_i) |=> tick16_o);
endmodule

bind baud_prescale_gen baud_prescale_chk #(
  .DIV_W(DIV_W), .ADDR_W(ADDR_W), .NBYTES(DIV_W / DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .strap_div4_i(strap_div4_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .tick16_o(tick16_o),
  .div_q(div_q), .sel_q(sel_q)
);

// File: tb/baud_prescale_gen_tb.sv
module baud_prescale_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baud_prescale_gen u_dut (
    .clk(clk), .rst(rst), .strap_div4_i(strap),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tick16_o(tick)
  );

  localparam int NV = 8;
  localparam int V_SEL [NV] = '{0, 0, 0, 1, 1, 0, 1, 0};
  localparam int V_DIV [NV] = '{1, 2, 5, 1, 3, 256, 258, 13};
  localparam int V_EXP [NV] = '{1, 2, 5, 4, 12, 256, 1032, 13};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
  endtask

  task automatic wait_tick(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < limit);
    if (!tick) n = -1;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; strap = s;
    repeat (3) begin
      @(negedge clk);
      check("R1 tick low in reset", int'(tick), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick low after reset", int'(tick), 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int hi;
    do_reset(1'b0);

    // R1 / R5: divisor is 0 after reset, so no enable appears
    hi = 0;
    repeat (60) begin @(negedge clk); hi += int'(tick); end
    check("R1 no tick before divisor set", hi, 0);

    // R4 / R7: walk the vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, V_SEL[i] != 0 ? 8'h80 : 8'h00);
      wr(2'd0, V_DIV[i][7:0]);
      wr(2'd1, V_DIV[i][15:8]);
      check("R7 tick low after divisor write", int'(tick), 0);
      wait_tick(5000, n);
      check("R7 first pulse offset", n, V_EXP[i]);
      wait_tick(5000, n);
      check("R4 pulse period", n, V_EXP[i]);
    end

    // R5: divisor 0 stops the enable
    set_div(0);
    hi = 0;
    repeat (100) begin @(negedge clk); hi += int'(tick); end
    check("R5 divisor zero silent", hi, 0);

    // R6: divisor 1, ratio 1 -> continuous
    wr(2'd2, 8'h00);
    set_div(1);
    @(negedge clk);
    hi = 0;
    repeat (20) begin @(negedge clk); hi += int'(tick); end
    check("R6 continuous enable", hi, 20);

    // R7: rewrite during continuous run -> low the next cycle
    wr(2'd0, 8'h01);
    check("R7 reload gap in continuous run", int'(tick), 0);

    // R8: ratio 1 -> 4 with divisor 1
    @(negedge clk);
    wr(2'd2, 8'h80);
    check("R8 tick low after ratio change", int'(tick), 0);
    wait_tick(100, n);
    check("R8 first pulse after switch to /4", n, 4);
    wait_tick(100, n);
    check("R8 period after switch to /4", n, 4);

    // R8: ratio 4 -> 1 at a mid-phase point
    @(negedge clk);
    wr(2'd2, 8'h00);
    check("R8 tick low after switch to /1", int'(tick), 0);
    wait_tick(100, n);
    check("R8 first pulse after switch to /1", n, 1);

    // R3: other control bits ignored, bit 7 clear keeps ratio 1
    wr(2'd2, 8'h7F);
    set_div(2);
    wait_tick(100, n);
    check("R3 low control bits ignored", n, 2);
    // R3: address 3 write changes nothing
    wr(2'd3, 8'hFF);
    wait_tick(100, n);
    wait_tick(100, n);
    check("R3 address 3 ignored", n, 2);

    // R2: strap high at reset selects /4
    do_reset(1'b1);
    set_div(2);
    wait_tick(100, n);
    check("R2 strap selects divide-by-4", n, 8);
    strap = 1'b0;
    wait_tick(100, n);
    check("R2 strap change after reset ignored", n, 8);
    // R3: software override of the strap
    wr(2'd2, 8'h00);
    set_div(2);
    wait_tick(100, n);
    check("R3 software override to divide-by-1", n, 2);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule